// File: doc/BRIEF.md
# DSP condition flag generator

This block produces the single condition bit (DC) of a fixed-point DSP datapath after every addition, subtraction or compare. Operands are 40-bit two's complement values: a 32-bit main field topped by 8 guard bits. The block recomputes the result at full precision (41 bits) and derives five indicators from it: carry/borrow, negative, zero, over-range and overflow. A 3-bit select field picks the indicator, or a signed comparison built from several of them. The choice is loaded into the DC register on a clock edge where the update strobe is high.

The signed comparison modes correct the sign of the result for over-range. When the true difference does not fit even in the 40-bit destination, the stored sign is wrong, and the block flips it. DC then always matches a scalar signed greater-than or greater-or-equal test on the same two operands. The overflow mode is stricter than the guard bits: it reports any result that leaves the 32-bit range, even when the guard bits could still hold it. The register file, instruction decode and saturation logic sit outside this block.

Top module: `dcf_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, DC becomes 0 at that edge.
- R2: When `dc_upd` is low at a rising edge (and reset is low), DC keeps its value.
- R3: `op_kind` selects the operation: 00 adds src1 and src2; 01 subtracts src2 from src1; 10 and 11 compare, which computes the same difference as 01. Every indicator comes from the exact 41-bit sign-extended result, and its low 40 bits form the stored result.
- R4: Select 000 gives carry/borrow. For an add it is the unsigned carry out of bit 39. For a subtract or compare it is 1 when src1 is below src2 taken as unsigned 40-bit numbers.
- R5: Select 001 gives negative, which is bit 39 of the 40-bit result.
- R6: Select 010 gives zero, which is 1 when all 40 result bits are 0.
- R7: Select 011 gives overflow, which is 1 unless result bits 39 down to 31 are all equal. A result that fits in the guard bits but not in 32 bits therefore sets DC.
- R8: Select 100 gives signed greater-than: DC = NOT((negative XOR over-range) OR zero). Over-range is bit 40 XOR bit 39 of the 41-bit result. After a subtract or compare, DC equals the signed test src1 > src2, even when the difference is over-range.
- R9: Select 101 gives signed greater-or-equal: DC = NOT(negative XOR over-range). After a subtract or compare, DC equals src1 >= src2 (signed).
- R10: Selects 110 and 111 are reserved. A strobe with either of them leaves DC unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears DC |
| dc_upd | input | 1 | Load strobe for DC |
| op_kind | input | 2 | Operation: 00 add, 01 subtract, 1x compare |
| cond_sel | input | 3 | Condition select, 000 to 101 active, 110/111 hold |
| src1 | input | 40 | First signed operand |
| src2 | input | 40 | Second signed operand |
| dc | output | 1 | Registered condition bit |

## Verification
The assertions assume that the operands, operation and select seen on a strobe edge are the values the checker samples one cycle later through `$past`. Inputs must therefore be stable across each edge. The comparison assertions assume the operation is a subtract or compare, so they are gated on `op_kind` not being 00. The bench changes inputs only on falling edges. Its random mix draws all four operation codes and all eight select codes, so the gated and the ungated cases both occur.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_CMP  = 2'b10,
        OP_CMPX = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        CS_CARRY = 3'b000,
        CS_NEG   = 3'b001,
        CS_ZERO  = 3'b010,
        CS_OVF   = 3'b011,
        CS_GT    = 3'b100,
        CS_GE    = 3'b101,
        CS_RSV6  = 3'b110,
        CS_RSV7  = 3'b111
    } cond_e;

    typedef struct packed {
        logic carry;
        logic neg;
        logic zero;
        logic ovr;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/dcf_arith.sv
module dcf_arith
    import dcf_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W:0]   full,
    output logic         carry_borrow
);
    logic [W:0] ext_a, ext_b, uadd;

    always_comb begin
        ext_a = {a[W-1], a};
        ext_b = {b[W-1], b};
        uadd  = {1'b0, a} + {1'b0, b};
        if (op == OP_ADD) begin
            full         = ext_a + ext_b;
            carry_borrow = uadd[W];
        end else begin
            full         = ext_a - ext_b;
            carry_borrow = (a < b);
        end
    end
endmodule

// File: rtl/dcf_flags.sv
module dcf_flags
    import dcf_pkg::*;
#(
    parameter int W     = 40,
    parameter int GUARD = 8
) (
    input  logic [W:0] full,
    input  logic       carry_borrow,
    output flags_t     flg
);
    localparam int MAIN = W - GUARD;
    localparam int FLD  = GUARD + 1;

    logic [FLD-1:0] field;

    always_comb begin
        field     = full[W-1:MAIN-1];
        flg.carry = carry_borrow;
        flg.neg   = full[W-1];
        flg.zero  = (full[W-1:0] == '0);
        flg.ovr   = full[W] ^ full[W-1];
        flg.ovf   = !((&field) || (~|field));
    end
endmodule

// File: rtl/dcf_select.sv
module dcf_select
    import dcf_pkg::*;
(
    input  flags_t flg,
    input  cond_e  sel,
    output logic   dc_next,
    output logic   hold
);
    always_comb begin
        dc_next = 1'b0;
        hold    = 1'b0;
        unique case (sel)
            CS_CARRY: dc_next = flg.carry;
            CS_NEG:   dc_next = flg.neg;
            CS_ZERO:  dc_next = flg.zero;
            CS_OVF:   dc_next = flg.ovf;
            CS_GT:    dc_next = !((flg.neg ^ flg.ovr) | flg.zero);
            CS_GE:    dc_next = !(flg.neg ^ flg.ovr);
            CS_RSV6,
            CS_RSV7:  hold    = 1'b1;
        endcase
    end
endmodule

// File: rtl/dcf_gen.sv
module dcf_gen
    import dcf_pkg::*;
#(
    parameter int W     = 40,
    parameter int GUARD = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dc_upd,
    input  logic [1:0]   op_kind,
    input  logic [2:0]   cond_sel,
    input  logic [W-1:0] src1,
    input  logic [W-1:0] src2,
    output logic         dc
);
    logic [W:0] full;
    logic       carry_borrow;
    flags_t     flg;
    logic       dc_next;
    logic       hold;
    logic       dc_q;
    logic       dc_d;

    dcf_arith #(.W(W)) u_arith (
        .a(src1), .b(src2), .op(op_e'(op_kind)),
        .full(full), .carry_borrow(carry_borrow)
    );

    dcf_flags #(.W(W), .GUARD(GUARD)) u_flags (
        .full(full), .carry_borrow(carry_borrow), .flg(flg)
    );

    dcf_select u_sel (
        .flg(flg), .sel(cond_e'(cond_sel)),
        .dc_next(dc_next), .hold(hold)
    );

    // next-value process
    always_comb begin
        dc_d = dc_q;
        if (dc_upd && !hold) dc_d = dc_next;
    end

    // register process
    always_ff @(posedge clk) begin
        if (rst) dc_q <= 1'b0;
        else     dc_q <= dc_d;
    end

    assign dc = dc_q;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !dc);
    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !dc_upd |=> $stable(dc));
    // R10
    a_r10_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (dc_upd && cond_sel[2:1] == 2'b11) |=> $stable(dc));
    // R6
    a_r6_zero_equal: assert property (@(posedge clk) disable iff (rst)
        (dc_upd && cond_sel == 3'b010 && op_kind != 2'b00)
        |=> (dc == ($past(src1) == $past(src2))));
    // R8
    a_r8_signed_gt: assert property (@(posedge clk) disable iff (rst)
        (dc_upd && cond_sel == 3'b100 && op_kind != 2'b00)
        |=> (dc == ($signed($past(src1)) > $signed($past(src2)))));
    // R9
    a_r9_signed_ge: assert property (@(posedge clk) disable iff (rst)
        (dc_upd && cond_sel == 3'b101 && op_kind != 2'b00)
        |=> (dc == ($signed($past(src1)) >= $signed($past(src2)))));
endmodule

// File: tb/sim_dcf_gen.sv
module sim_dcf_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dc_upd = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [2:0]  cond_sel = 3'b000;
    logic [39:0] src1 = '0;
    logic [39:0] src2 = '0;
    logic        dc;

    int checks = 0;
    int errors = 0;
    logic model = 1'b0;

    dcf_gen u0 (.clk(clk), .rst(rst), .dc_upd(dc_upd), .op_kind(op_kind),
                .cond_sel(cond_sel), .src1(src1), .src2(src2), .dc(dc));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic calc(input logic [1:0] op, input logic [2:0] sel,
                                  input logic [39:0] a, input logic [39:0] b,
                                  input logic prev);
        logic signed [40:0] t;
        logic [39:0] w;
        logic [40:0] u;
        t = (op == 2'b00) ? ($signed({a[39], a}) + $signed({b[39], b}))
                          : ($signed({a[39], a}) - $signed({b[39], b}));
        w = t[39:0];
        u = {1'b0, a} + {1'b0, b};
        case (sel)
            3'd0: return (op == 2'b00) ? u[40] : (a < b);
            3'd1: return w[39];
            3'd2: return (w == 40'd0);
            3'd3: return !(w[39:31] == 9'h1FF || w[39:31] == 9'h000);
            3'd4: return (t > 0);
            3'd5: return (t >= 0);
            default: return prev;
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (dc !== exp) begin
            errors++;
            $display("FAIL %s dc=%b expected=%b (op=%b sel=%b a=%h b=%h)",
                     req, dc, exp, op_kind, cond_sel, src1, src2);
        end
    endtask

    task automatic step(input string req, input logic upd, input logic [1:0] op,
                        input logic [2:0] sel, input logic [39:0] a,
                        input logic [39:0] b);
        @(negedge clk);
        dc_upd = upd; op_kind = op; cond_sel = sel; src1 = a; src2 = b;
        if (upd) model = calc(op, sel, a, b, model);
        @(posedge clk);
        #1;
        check(req, model);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dc_upd = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        model = 1'b0;
        check("R1", model);
        @(negedge clk);
        rst = 1'b0;
    endtask

    localparam logic [39:0] MAXP = 40'h7F_FFFF_FFFF;
    localparam logic [39:0] MINN = 40'h80_0000_0000;

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        do_reset();
        // R8 over-range: max minus min is positive though sign flips
        step("R8", 1, 2'b10, 3'd4, MAXP, MINN);
        step("R8", 1, 2'b10, 3'd4, MINN, MAXP);
        step("R9", 1, 2'b01, 3'd5, MINN, MAXP);
        step("R9", 1, 2'b10, 3'd5, 40'h12_3456_789A, 40'h12_3456_789A);
        step("R8", 1, 2'b11, 3'd4, 40'h12_3456_789A, 40'h12_3456_789A);
        step("R6", 1, 2'b10, 3'd2, 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF);
        // R7 guard bits in use still flag overflow
        step("R7", 1, 2'b00, 3'd3, 40'h00_7FFF_FFFF, 40'h00_0000_0001);
        step("R7", 1, 2'b00, 3'd3, 40'hFF_8000_0000, 40'h00_0000_0000);
        step("R7", 1, 2'b01, 3'd3, 40'hFF_8000_0000, 40'h00_0000_0001);
        step("R4", 1, 2'b00, 3'd0, 40'hFF_FFFF_FFFF, 40'h00_0000_0001);
        step("R4", 1, 2'b01, 3'd0, 40'h00_0000_0001, 40'h00_0000_0002);
        step("R5", 1, 2'b00, 3'd1, MAXP, 40'h00_0000_0001);
        step("R3", 1, 2'b00, 3'd2, 40'h00_0000_0005, 40'hFF_FFFF_FFFB);
        // R10 reserved and R2 idle leave dc as is
        step("R8", 1, 2'b10, 3'd4, 40'd9, 40'd3);
        step("R10", 1, 2'b10, 3'd6, 40'd3, 40'd9);
        step("R10", 1, 2'b10, 3'd7, 40'd3, 40'd9);
        step("R2", 0, 2'b10, 3'd5, 40'd3, 40'd9);
        do_reset();

        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [39:0] a, b;
            logic [2:0] sel;
            a = {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
            b = {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
            if ($urandom_range(3) == 0) b = a;
            if ($urandom_range(3) == 0) a = {{9{a[39]}}, a[30:0]};
            sel = 3'($urandom_range(7));
            step(sel == 3'd0 ? "R4" : sel == 3'd1 ? "R5" : sel == 3'd2 ? "R6" :
                 sel == 3'd3 ? "R7" : sel == 3'd4 ? "R8" : sel == 3'd5 ? "R9" : "R10",
                 ($urandom_range(7) != 0), 2'($urandom_range(3)), sel, a, b);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule